// File: doc/BRIEF.md
# Calendar Alarm Match Controller

This block watches the live BCD calendar produced by a timekeeper and raises an alarm when the time reaches a programmed moment. Six alarm bytes hold target values for the seconds, minutes, hours, day of month, month and day of week. The top bit of each byte is a per-field enable. Only the enabled fields take part in the comparison. The year is never compared, and there is no master enable: an alarm with no enabled field never fires.

The comparison runs once per second, in the cycle where the timekeeper pulses its one-second tick and presents the freshly updated time. A match sets a sticky alarm flag in a status byte. It also drives an active-low interrupt.

A control byte sets two behaviours:
- Whether a host read of the status byte clears the flag by itself.
- Whether the interrupt is a level that follows the flag, or a fixed-length pulse on every matching second.

Software reaches every byte through a simple single-cycle register port.

Top module: `alarm_match_ctrl`

## Requirements
- R1: After reset, every alarm byte, the control byte and the status byte read 0, and `alarm_irq_n` is 1.
- R2: Alarm bytes sit at addresses 0x10 (seconds), 0x11 (minutes), 0x12 (hours), 0x13 (date), 0x14 (month) and 0x15 (weekday). Each stores and reads back all 8 bits, with bit 7 as the field enable. Any address other than 0x07, 0x08 and 0x10 to 0x15 reads 0.
- R3: A match requires two things on a cycle with `sec_tick` high: at least one enabled field, and every enabled field equal to its time input. The match sets the alarm flag, bit 4 of the status byte at 0x07, on the following cycle. The other status bits read 0.
- R4: A field whose enable bit is 0 does not block a match, whatever its value.
- R5: With all six enable bits at 0, no tick ever sets the alarm flag.
- R6: Without `sec_tick`, equal time values never set the alarm flag.
- R7: When control bit 7 (auto-clear) at 0x08 is 1, a host read of 0x07 returns the flag as it stands, and the flag is 0 from the next cycle on.
- R8: When auto-clear is 0, reads leave the flag alone. A host write to 0x07 with bit 4 at 0 clears the flag. A write with bit 4 at 1 never sets it.
- R9: When control bit 5 at 0x08 is 0 (level mode), `alarm_irq_n` is low exactly while the alarm flag is 1.
- R10: When control bit 5 is 1 (pulse mode), `alarm_irq_n` is low for `PULSE_CYC` cycles (default 8). The pulse starts in the cycle after each matching tick and does not depend on the flag.
- R11: If a match and a clear request fall in the same cycle, the flag ends up set.
- R12: The comparison uses only the value bits of each field: 7 bits for seconds and minutes, 6 for hours and date, 5 for month and 3 for weekday. Higher bits of the time inputs and of the alarm bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse when the time inputs have just advanced |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD (bit 7 carries the 24-hour flag) |
| now_date | input | 8 | Current day of month, BCD |
| now_month | input | 8 | Current month, BCD |
| now_wday | input | 8 | Current day of week, 0 to 6 |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effects only) |
| host_addr | input | 8 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| alarm_irq_n | output | 1 | Active-low alarm interrupt |

## Verification
Each fault inside the block shows up at the ports within a small, fixed number of cycles:
- A broken field comparison or mask makes the status byte differ from the expected value one cycle after the offending tick.
- A wrong clear path shows up in the next status read.
- A miscounted pulse changes `alarm_irq_n` within `PULSE_CYC` + 1 cycles of the match.

A behavioural model in the bench predicts `host_rdata` and `alarm_irq_n` on every clock. Any divergence is therefore reported within the cycle where it first becomes visible.

// File: rtl/alm_pkg.sv
package alm_pkg;

  localparam int NFIELD = 6;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_WDAY  = 3'd5
  } alm_field_e;

  localparam logic [7:0] ADDR_STATUS   = 8'h07;
  localparam logic [7:0] ADDR_CTRL     = 8'h08;
  localparam logic [7:0] ADDR_ALM_BASE = 8'h10;

  localparam int STAT_FLAG_BIT = 4;
  localparam int CTRL_AUTO_BIT = 7;
  localparam int CTRL_PULS_BIT = 5;
  localparam int FIELD_EN_BIT  = 7;

  // value bits that take part in a comparison, per field
  function automatic logic [6:0] field_mask(input int idx);
    case (idx)
      int'(FLD_SEC), int'(FLD_MIN):   field_mask = 7'h7F;
      int'(FLD_HOUR), int'(FLD_DATE): field_mask = 7'h3F;
      int'(FLD_MONTH):                field_mask = 7'h1F;
      default:                        field_mask = 7'h07;
    endcase
  endfunction

  // one enabled field agrees with the live time value
  function automatic logic field_equal(input logic [7:0] alm_byte,
                                       input logic [7:0] now_byte,
                                       input int idx);
    field_equal = ((alm_byte[6:0] ^ now_byte[6:0]) & field_mask(idx)) == 7'h00;
  endfunction

endpackage

// File: rtl/alm_regfile.sv
module alm_regfile
  import alm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            addr,
  input  logic [7:0]            wdata,
  input  logic                  flag_q,
  output logic [NFIELD-1:0][7:0] alm_bytes,
  output logic                  auto_clr,
  output logic                  pulse_mode,
  output logic [7:0]            rdata
);

  logic [NFIELD-1:0] sel_fld;

  genvar g;
  generate
    for (g = 0; g < NFIELD; g++) begin : g_fld
      assign sel_fld[g] = (addr == ADDR_ALM_BASE + 8'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                alm_bytes[g] <= 8'h00;
        else if (wr_en && sel_fld[g]) alm_bytes[g] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_clr   <= 1'b0;
      pulse_mode <= 1'b0;
    end else if (wr_en && addr == ADDR_CTRL) begin
      auto_clr   <= wdata[CTRL_AUTO_BIT];
      pulse_mode <= wdata[CTRL_PULS_BIT];
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == ADDR_STATUS) begin
      rdata[STAT_FLAG_BIT] = flag_q;
    end else if (addr == ADDR_CTRL) begin
      rdata[CTRL_AUTO_BIT] = auto_clr;
      rdata[CTRL_PULS_BIT] = pulse_mode;
    end else begin
      for (int i = 0; i < NFIELD; i++)
        if (sel_fld[i]) rdata = alm_bytes[i];
    end
  end

endmodule

// File: rtl/alm_cmp.sv
module alm_cmp
  import alm_pkg::*;
(
  input  logic                   tick,
  input  logic [NFIELD-1:0][7:0] alm_bytes,
  input  logic [NFIELD-1:0][7:0] now_bytes,
  output logic [NFIELD-1:0]      en_vec,
  output logic                   hit
);

  logic [NFIELD-1:0] ok_vec;

  genvar g;
  generate
    for (g = 0; g < NFIELD; g++) begin : g_cmp
      assign en_vec[g] = alm_bytes[g][FIELD_EN_BIT];
      assign ok_vec[g] = !en_vec[g] || field_equal(alm_bytes[g], now_bytes[g], g);
    end
  endgenerate

  assign hit = tick && (|en_vec) && (&ok_vec);

endmodule

// File: rtl/alm_irq.sv
module alm_irq #(
  parameter int PULSE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic rd_status,
  input  logic wr_status,
  input  logic wr_flag_bit,
  input  logic auto_clr,
  input  logic pulse_mode,
  output logic flag_q,
  output logic irq_n
);

  localparam int CW = $clog2(PULSE_CYC + 1);

  logic          clr_req;
  logic [CW-1:0] pcnt;

  assign clr_req = (rd_status && auto_clr) || (wr_status && !wr_flag_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (hit)     flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pcnt <= '0;
    else if (hit)          pcnt <= CW'(PULSE_CYC);
    else if (pcnt != '0)   pcnt <= pcnt - 1'b1;
  end

  assign irq_n = pulse_mode ? (pcnt == '0) : !flag_q;

  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_req));

  // R11
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr_req) |=> flag_q);

endmodule

// File: rtl/alarm_match_ctrl.sv
module alarm_match_ctrl
  import alm_pkg::*;
#(
  parameter int PULSE_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] now_date,
  input  logic [7:0] now_month,
  input  logic [7:0] now_wday,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       alarm_irq_n
);

  logic [NFIELD-1:0][7:0] alm_bytes;
  logic [NFIELD-1:0][7:0] now_bytes;
  logic [NFIELD-1:0]      en_vec;
  logic                   hit;
  logic                   flag_q;
  logic                   auto_clr;
  logic                   pulse_mode;
  logic                   rd_status;
  logic                   wr_status;

  assign now_bytes[FLD_SEC]   = now_sec;
  assign now_bytes[FLD_MIN]   = now_min;
  assign now_bytes[FLD_HOUR]  = now_hour;
  assign now_bytes[FLD_DATE]  = now_date;
  assign now_bytes[FLD_MONTH] = now_month;
  assign now_bytes[FLD_WDAY]  = now_wday;

  assign rd_status = host_rd && (host_addr == ADDR_STATUS);
  assign wr_status = host_wr && (host_addr == ADDR_STATUS);

  alm_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (host_wr),
    .addr       (host_addr),
    .wdata      (host_wdata),
    .flag_q     (flag_q),
    .alm_bytes  (alm_bytes),
    .auto_clr   (auto_clr),
    .pulse_mode (pulse_mode),
    .rdata      (host_rdata)
  );

  alm_cmp u_cmp (
    .tick      (sec_tick),
    .alm_bytes (alm_bytes),
    .now_bytes (now_bytes),
    .en_vec    (en_vec),
    .hit       (hit)
  );

  alm_irq #(.PULSE_CYC(PULSE_CYC)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (hit),
    .rd_status   (rd_status),
    .wr_status   (wr_status),
    .wr_flag_bit (host_wdata[STAT_FLAG_BIT]),
    .auto_clr    (auto_clr),
    .pulse_mode  (pulse_mode),
    .flag_q      (flag_q),
    .irq_n       (alarm_irq_n)
  );

  // R5
  no_enable_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |-> !hit);

  // R6
  no_tick_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |-> !hit);

  // R3
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> host_rdata[STAT_FLAG_BIT] || host_addr != ADDR_STATUS);

  // R9
  irq_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !(host_wr && host_addr == ADDR_CTRL)) |=> !alarm_irq_n);

endmodule

// File: tb/alarm_match_ctrl_bench.sv
module alarm_match_ctrl_bench;

  localparam int PCYC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00;
  logic [7:0] now_date = 8'h01, now_month = 8'h01, now_wday = 8'h00;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_addr = 8'h00, host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       alarm_irq_n;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  alarm_match_ctrl #(.PULSE_CYC(PCYC)) u_alarm_match_ctrl (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_date(now_date), .now_month(now_month), .now_wday(now_wday),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .alarm_irq_n(alarm_irq_n)
  );

  // ---------------- reference model ----------------
  int m_alm[6];
  int m_auto, m_puls, m_flag, m_cnt;

  function automatic int span(input int i);
    case (i)
      0, 1:    span = 128;
      2, 3:    span = 64;
      4:       span = 32;
      default: span = 8;
    endcase
  endfunction

  function automatic int now_of(input int i);
    case (i)
      0: now_of = now_sec;   1: now_of = now_min;
      2: now_of = now_hour;  3: now_of = now_date;
      4: now_of = now_month; default: now_of = now_wday;
    endcase
  endfunction

  function automatic bit model_match();
    int n_en = 0;
    bit ok = 1;
    for (int i = 0; i < 6; i++) begin
      if (m_alm[i] >= 128) begin
        n_en++;
        if ((m_alm[i] % span(i)) != (now_of(i) % span(i))) ok = 0;
      end
    end
    model_match = (n_en > 0) && ok;
  endfunction

  function automatic int model_rd(input int a);
    if (a == 7)                 model_rd = m_flag * 16;
    else if (a == 8)            model_rd = m_auto * 128 + m_puls * 32;
    else if (a >= 16 && a < 22) model_rd = m_alm[a-16];
    else                        model_rd = 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_alm[i]) m_alm[i] = 0;
      m_auto = 0; m_puls = 0; m_flag = 0; m_cnt = 0;
    end else begin
      bit h;
      bit clr;
      h = sec_tick && model_match();
      clr = (host_rd && host_addr == 8'h07 && m_auto == 1) ||
            (host_wr && host_addr == 8'h07 && host_wdata[4] == 1'b0);
      if (h) m_flag = 1; else if (clr) m_flag = 0;
      if (h) m_cnt = PCYC; else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (host_wr) begin
        if (host_addr == 8'h08) begin
          m_auto = host_wdata[7];
          m_puls = host_wdata[5];
        end else if (host_addr >= 8'h10 && host_addr < 8'h16) begin
          m_alm[host_addr-8'h10] = host_wdata;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int exp_rd;
      bit exp_irq;
      exp_rd  = model_rd(host_addr);
      exp_irq = (m_puls == 1) ? (m_cnt == 0) : (m_flag == 0);
      checks += 2;
      if (host_rdata !== 8'(exp_rd)) begin
        errors++;
        $display("FAIL %s rdata addr=%02h actual=%02h expected=%02h", phase, host_addr, host_rdata, exp_rd);
      end
      if (alarm_irq_n !== exp_irq) begin
        errors++;
        $display("FAIL %s irq_n actual=%0b expected=%0b", phase, alarm_irq_n, exp_irq);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic next_cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    next_cyc();
    host_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a);
    host_rd = 1'b1; host_addr = a;
    next_cyc();
    host_rd = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    host_addr = a;
    @(negedge clk);
    checks++;
    if (host_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%02h actual=%02h expected=%02h", req, a, host_rdata, exp);
    end
    next_cyc();
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, d, mo, w);
    now_sec = s; now_min = mi; now_hour = h;
    now_date = d; now_month = mo; now_wday = w;
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    next_cyc();
    sec_tick = 1'b0;
  endtask

  task automatic clear_all_alarms();
    for (int i = 0; i < 6; i++) wr_reg(8'h10 + 8'(i), 8'h00);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    next_cyc();

    // R1 reset state
    phase = "R1";
    expect_rd(8'h07, 8'h00, "R1");
    expect_rd(8'h08, 8'h00, "R1");
    for (int i = 0; i < 6; i++) expect_rd(8'h10 + 8'(i), 8'h00, "R1");

    // R2 storage and readback
    phase = "R2";
    wr_reg(8'h10, 8'hB0);
    wr_reg(8'h11, 8'h95);
    wr_reg(8'h12, 8'h23);
    wr_reg(8'h13, 8'h7F);
    wr_reg(8'h14, 8'h12);
    wr_reg(8'h15, 8'h06);
    expect_rd(8'h10, 8'hB0, "R2");
    expect_rd(8'h13, 8'h7F, "R2");
    expect_rd(8'h15, 8'h06, "R2");
    expect_rd(8'h20, 8'h00, "R2");
    expect_rd(8'h09, 8'h00, "R2");

    // R4 disabled fields differ from time; R3 only sec/min enabled
    phase = "R3";
    set_time(8'h29, 8'h15, 8'h08, 8'h04, 8'h03, 8'h02);
    tick();
    expect_rd(8'h07, 8'h00, "R3");
    phase = "R4";
    set_time(8'h30, 8'h15, 8'h08, 8'h04, 8'h03, 8'h02);
    tick();
    expect_rd(8'h07, 8'h10, "R4");

    // R8 manual clear only
    phase = "R8";
    rd_reg(8'h07);
    expect_rd(8'h07, 8'h10, "R8");
    wr_reg(8'h07, 8'h10);
    expect_rd(8'h07, 8'h10, "R8");
    wr_reg(8'h07, 8'hEF);
    expect_rd(8'h07, 8'h00, "R8");

    // R6 equal time but no tick
    phase = "R6";
    set_time(8'h30, 8'h15, 8'h08, 8'h04, 8'h03, 8'h02);
    repeat (5) next_cyc();
    expect_rd(8'h07, 8'h00, "R6");

    // R5 no enables at all
    phase = "R5";
    clear_all_alarms();
    wr_reg(8'h10, 8'h30);
    wr_reg(8'h11, 8'h15);
    tick();
    tick();
    expect_rd(8'h07, 8'h00, "R5");

    // R7 auto-clear on status read
    phase = "R7";
    wr_reg(8'h08, 8'h80);
    wr_reg(8'h10, 8'hB0);
    tick();
    host_rd = 1'b1; host_addr = 8'h07;
    @(negedge clk);
    checks++;
    if (host_rdata !== 8'h10) begin
      errors++;
      $display("FAIL R7 read actual=%02h expected=10", host_rdata);
    end
    next_cyc();
    host_rd = 1'b0;
    expect_rd(8'h07, 8'h00, "R7");

    // R9 level interrupt follows flag
    phase = "R9";
    wr_reg(8'h08, 8'h00);
    tick();
    repeat (12) next_cyc();
    wr_reg(8'h07, 8'h00);
    repeat (2) next_cyc();

    // R10 pulse mode, two matching seconds
    phase = "R10";
    wr_reg(8'h08, 8'h20);
    tick();
    repeat (PCYC + 3) next_cyc();
    tick();
    repeat (PCYC + 3) next_cyc();
    wr_reg(8'h07, 8'h00);

    // R11 match and clear in the same cycle
    phase = "R11";
    wr_reg(8'h08, 8'h00);
    sec_tick = 1'b1; host_wr = 1'b1; host_addr = 8'h07; host_wdata = 8'h00;
    next_cyc();
    sec_tick = 1'b0; host_wr = 1'b0;
    expect_rd(8'h07, 8'h10, "R11");
    wr_reg(8'h07, 8'h00);

    // R12 value masks: hour flag bits and wide weekday ignored
    phase = "R12";
    clear_all_alarms();
    wr_reg(8'h12, 8'hD2);
    wr_reg(8'h15, 8'hFB);
    set_time(8'h00, 8'h00, 8'h92, 8'h01, 8'h01, 8'h43);
    tick();
    expect_rd(8'h07, 8'h10, "R12");
    wr_reg(8'h07, 8'h00);
    set_time(8'h00, 8'h00, 8'h92, 8'h01, 8'h01, 8'h02);
    tick();
    expect_rd(8'h07, 8'h00, "R12");

    repeat (3) next_cyc();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule